// File: doc/BRIEF.md
# Volts-per-hertz speed command chain

This block turns a speed reference into the two commands that set an induction motor's supply: a stator frequency command and a stator voltage magnitude command. It is for a motoring-only drive. The reference first passes through a soft-start lag, so that steps in the requested speed become ramps. A PI regulator then acts on the difference between the ramped reference and a measured-speed sample. Its output is a torque demand. That demand is held between zero and an adjustable ceiling and is used directly as the slip command.

The slip is added to the measured speed to give the frequency command. The voltage command follows a straight line in frequency: an offset for stator resistive drop plus a gain times the frequency. It is capped at rated voltage, so the motor runs flux-weakened above base speed.

Every value is unsigned Q1.15, where 0x8000 is 1.0 pu. The chain advances once per sample strobe. Gains, ceiling, offset and slope come from register inputs that the surrounding logic holds steady.

Top module: `vhz_cmd_chain`

## Requirements
- R1: A synchronous active-high reset clears the soft-start state, the integrator and the outputs `slip_cmd`, `freq_cmd` and `volt_cmd` to zero.
- R2: On each strobe the soft-start state S becomes S + floor((spd_ref - S) / 2^ss_shift). With ss_shift = 0 the reference passes through in one strobe.
- R3: While `smp_stb` is low, every output and all internal state hold their values, whatever the other inputs do.
- R4: Let e be the new soft-start state minus `spd_meas`. On each strobe the raw demand is u = floor(kp*e/4096) + I + floor(ki*e/4096). Here kp and ki are unsigned Q4.12 and I is the integrator value before the strobe.
- R5: `slip_cmd` is u clamped to the range 0 to `trq_lim`. It is registered on the strobe.
- R6: `freq_cmd` is `slip_cmd` + `spd_meas`, saturating at 0xFFFF. It is registered on the same strobe.
- R7: `volt_cmd` is `volt_off` + floor(`volt_gain` * `freq_cmd` / 32768), limited to 0x8000 (1.0 pu). `volt_gain` is Q1.15.
- R8: The integrator takes I + floor(ki*e/4096) on a strobe, except when u exceeds `trq_lim` with e > 0, or when u < 0 with e < 0. In those cases it holds, so the integrator never goes negative and a clamped demand leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle sample strobe that advances the chain |
| spd_ref | input | 16 | Speed reference, Q1.15 pu |
| spd_meas | input | 16 | Measured rotor speed, Q1.15 pu |
| ss_shift | input | 4 | Soft-start lag, time constant 2^ss_shift strobes |
| kp | input | 16 | Proportional gain, Q4.12 |
| ki | input | 16 | Integral gain per sample, Q4.12 |
| trq_lim | input | 16 | Torque/slip ceiling, Q1.15 |
| volt_off | input | 16 | Voltage offset, Q1.15 |
| volt_gain | input | 16 | Voltage-per-frequency slope, Q1.15 |
| slip_cmd | output | 16 | Clamped torque demand used as slip, Q1.15 |
| freq_cmd | output | 16 | Stator frequency command, Q1.15 |
| volt_cmd | output | 16 | Stator voltage command, Q1.15 |

## Verification
The integrator freeze is the hardest behaviour to reach, because the integrator cannot be seen directly. It appears only later, as the absence of stored charge once the demand leaves the ceiling. The stimulus sets a zero proportional gain and a low ceiling, then holds the reference far above the measured speed for many strobes, so the demand stays pinned at the ceiling. It then drops the reference to just above the measured speed. The very next slip must equal the small new integral step alone, with no wound-up excess.

// File: rtl/vhz_pkg.sv
package vhz_pkg;
  localparam int DW    = 16;  // Q1.15 data width
  localparam int EW    = DW + 2;  // signed error width
  localparam int GFRAC = 12;  // gain fractional bits (Q4.12)
  localparam int PW    = 36;  // product / accumulator width
  localparam int IW    = 24;  // integrator register width
  localparam int VFRAC = DW - 1;  // Q1.15 fraction bits
  localparam logic [DW-1:0] ONE_PU = 16'h8000;

  // soft-start step: move by floor(diff / 2^sh)
  function automatic logic [DW-1:0] ss_step(input logic [DW-1:0] st,
                                            input logic [DW-1:0] tgt,
                                            input logic [3:0] sh);
    logic signed [EW-1:0] d;
    logic signed [EW-1:0] s;
    d = $signed({2'b00, tgt}) - $signed({2'b00, st});
    d = d >>> sh;
    s = $signed({2'b00, st}) + d;
    return s[DW-1:0];
  endfunction

  // gain (unsigned Q4.12) times signed error, floored
  function automatic logic signed [PW-1:0] gain_mul(input logic [DW-1:0] g,
                                                    input logic signed [EW-1:0] e);
    logic signed [PW-1:0] pr;
    pr = $signed({{(PW-DW){1'b0}}, g}) * $signed({{(PW-EW){e[EW-1]}}, e});
    return pr >>> GFRAC;
  endfunction

  // clamp raw demand into [0, lim]
  function automatic logic [DW-1:0] trq_clamp(input logic signed [PW-1:0] u,
                                              input logic [DW-1:0] lim);
    if (u < 0) return '0;
    if (u > $signed({{(PW-DW){1'b0}}, lim})) return lim;
    return u[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] freq_law(input logic [DW-1:0] slip,
                                             input logic [DW-1:0] meas);
    logic [DW:0] s;
    s = {1'b0, slip} + {1'b0, meas};
    return s[DW] ? {DW{1'b1}} : s[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] volt_law(input logic [DW-1:0] f,
                                             input logic [DW-1:0] voff,
                                             input logic [DW-1:0] kv);
    logic [2*DW-1:0] pr;
    logic [DW+1:0]   v;
    pr = {{DW{1'b0}}, kv} * {{DW{1'b0}}, f};
    v  = {2'b00, voff} + pr[VFRAC+DW:VFRAC];
    return (v > {2'b00, ONE_PU}) ? ONE_PU : v[DW-1:0];
  endfunction
endpackage

// File: rtl/vhz_softstart.sv
module vhz_softstart
  import vhz_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic [DW-1:0] tgt_i,
  input  logic [3:0]    shift_i,
  output logic [DW-1:0] ss_next_o
);
  logic [DW-1:0] ss_q;

  assign ss_next_o = ss_step(ss_q, tgt_i, shift_i);

  always_ff @(posedge clk) begin
    if (rst)      ss_q <= '0;
    else if (stb) ss_q <= ss_next_o;
  end

  // state moves toward the reference and never past it
  AST_SS_TOWARD_UP: assert property (@(posedge clk) disable iff (rst)
    (stb && tgt_i >= ss_q) |=> (ss_q <= $past(tgt_i) && ss_q >= $past(ss_q))); // R2
  AST_SS_TOWARD_DN: assert property (@(posedge clk) disable iff (rst)
    (stb && tgt_i < ss_q) |=> (ss_q >= $past(tgt_i) && ss_q <= $past(ss_q))); // R2
  AST_SS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(ss_q)); // R3
endmodule

// File: rtl/vhz_pi_reg.sv
module vhz_pi_reg
  import vhz_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic [DW-1:0] ss_i,
  input  logic [DW-1:0] meas_i,
  input  logic [DW-1:0] kp_i,
  input  logic [DW-1:0] ki_i,
  input  logic [DW-1:0] lim_i,
  output logic [DW-1:0] trq_o
);
  logic signed [IW-1:0] integ_q;
  logic signed [EW-1:0] err;
  logic signed [PW-1:0] p_term, i_inc, i_cand, u_raw;
  logic                 freeze_w;

  assign err    = $signed({2'b00, ss_i}) - $signed({2'b00, meas_i});
  assign p_term = gain_mul(kp_i, err);
  assign i_inc  = gain_mul(ki_i, err);
  assign i_cand = $signed({{(PW-IW){integ_q[IW-1]}}, integ_q}) + i_inc;
  assign u_raw  = p_term + i_cand;

  // anti-windup: hold when the clamp opposes the error's push
  assign freeze_w = ((u_raw > $signed({{(PW-DW){1'b0}}, lim_i})) && (err > 0)) ||
                    ((u_raw < 0) && (err < 0));

  assign trq_o = trq_clamp(u_raw, lim_i);

  always_ff @(posedge clk) begin
    if (rst)                   integ_q <= '0;
    else if (stb && !freeze_w) integ_q <= i_cand[IW-1:0];
  end

  AST_AW_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (stb && freeze_w) |=> $stable(integ_q)); // R8
  AST_INT_NONNEG: assert property (@(posedge clk) disable iff (rst)
    integ_q >= 0); // R8
  AST_INT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(integ_q)); // R3
endmodule

// File: rtl/vhz_vlaw.sv
module vhz_vlaw
  import vhz_pkg::*;
(
  input  logic [DW-1:0] slip_i,
  input  logic [DW-1:0] meas_i,
  input  logic [DW-1:0] voff_i,
  input  logic [DW-1:0] kv_i,
  output logic [DW-1:0] freq_o,
  output logic [DW-1:0] volt_o
);
  assign freq_o = freq_law(slip_i, meas_i);
  assign volt_o = volt_law(freq_o, voff_i, kv_i);
endmodule

// File: rtl/vhz_cmd_chain.sv
module vhz_cmd_chain
  import vhz_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_stb,
  input  logic [DW-1:0] spd_ref,
  input  logic [DW-1:0] spd_meas,
  input  logic [3:0]    ss_shift,
  input  logic [DW-1:0] kp,
  input  logic [DW-1:0] ki,
  input  logic [DW-1:0] trq_lim,
  input  logic [DW-1:0] volt_off,
  input  logic [DW-1:0] volt_gain,
  output logic [DW-1:0] slip_cmd,
  output logic [DW-1:0] freq_cmd,
  output logic [DW-1:0] volt_cmd
);
  logic [DW-1:0] ss_next, trq_w, freq_w, volt_w;

  vhz_softstart u_ss (
    .clk(clk), .rst(rst), .stb(smp_stb),
    .tgt_i(spd_ref), .shift_i(ss_shift), .ss_next_o(ss_next)
  );

  vhz_pi_reg u_pi (
    .clk(clk), .rst(rst), .stb(smp_stb),
    .ss_i(ss_next), .meas_i(spd_meas), .kp_i(kp), .ki_i(ki),
    .lim_i(trq_lim), .trq_o(trq_w)
  );

  vhz_vlaw u_vl (
    .slip_i(trq_w), .meas_i(spd_meas), .voff_i(volt_off), .kv_i(volt_gain),
    .freq_o(freq_w), .volt_o(volt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slip_cmd <= '0;
      freq_cmd <= '0;
      volt_cmd <= '0;
    end else if (smp_stb) begin
      slip_cmd <= trq_w;
      freq_cmd <= freq_w;
      volt_cmd <= volt_w;
    end
  end

  AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ($stable(freq_cmd) && $stable(volt_cmd) && $stable(slip_cmd))); // R3
  AST_TRQ_CEIL: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> slip_cmd <= $past(trq_lim)); // R5
  AST_FREQ_FLOOR: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> freq_cmd >= $past(spd_meas)); // R6
  AST_VOLT_CEIL: assert property (@(posedge clk) disable iff (rst)
    volt_cmd <= ONE_PU); // R7
endmodule

// File: tb/vhz_cmd_chain_tb_top.sv
`timescale 1ns/1ps
module vhz_cmd_chain_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_stb = 1'b0;
  logic [15:0] spd_ref = '0, spd_meas = '0;
  logic [3:0]  ss_shift = '0;
  logic [15:0] kp = '0, ki = '0, trq_lim = '0, volt_off = '0, volt_gain = '0;
  logic [15:0] slip_cmd, freq_cmd, volt_cmd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  longint m_ss = 0, m_int = 0;
  longint e_slip = 0, e_freq = 0, e_volt = 0;

  always #2.5 clk = ~clk;

  vhz_cmd_chain dut_i (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .spd_ref(spd_ref), .spd_meas(spd_meas),
    .ss_shift(ss_shift), .kp(kp), .ki(ki), .trq_lim(trq_lim), .volt_off(volt_off),
    .volt_gain(volt_gain), .slip_cmd(slip_cmd), .freq_cmd(freq_cmd), .volt_cmd(volt_cmd)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model of one sample, written from the requirements
  task automatic model(input longint r, input longint m);
    longint d, e, p, inc, ic, u, f, v;
    d = r - m_ss;
    d = d >>> ss_shift;                  // R2 floor step
    m_ss = m_ss + d;
    e = m_ss - m;
    p = (longint'(kp) * e) >>> 12;       // R4
    inc = (longint'(ki) * e) >>> 12;
    ic = m_int + inc;
    u = p + ic;
    if (!((u > longint'(trq_lim) && e > 0) || (u < 0 && e < 0))) m_int = ic;  // R8
    e_slip = (u < 0) ? 0 : ((u > longint'(trq_lim)) ? longint'(trq_lim) : u);  // R5
    f = e_slip + m;
    e_freq = (f > 65535) ? 65535 : f;    // R6
    v = longint'(volt_off) + ((longint'(volt_gain) * e_freq) >>> 15);
    e_volt = (v > 32768) ? 32768 : v;    // R7
  endtask

  task automatic step(input logic [15:0] r, input logic [15:0] m, input string tag);
    @(negedge clk);
    spd_ref = r; spd_meas = m; smp_stb = 1'b1;
    model(longint'(r), longint'(m));
    @(negedge clk);
    smp_stb = 1'b0;
    chk({tag, " slip"}, longint'(slip_cmd), e_slip);
    chk({tag, " freq"}, longint'(freq_cmd), e_freq);
    chk({tag, " volt"}, longint'(volt_cmd), e_volt);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; smp_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_ss = 0; m_int = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 slip", longint'(slip_cmd), 0);
    chk("R1 freq", longint'(freq_cmd), 0);
    chk("R1 volt", longint'(volt_cmd), 0);
  endtask

  task automatic t_passthru();
    ss_shift = 4'd0; kp = 16'h1000; ki = 16'h0000; trq_lim = 16'h8000;
    volt_off = 16'h0000; volt_gain = 16'h8000;
    step(16'h2000, 16'h1000, "R2 R4 R6 R7 passthru");
    chk("R4 direct slip", longint'(slip_cmd), 64'h1000);
    chk("R6 direct freq", longint'(freq_cmd), 64'h2000);
  endtask

  task automatic t_ramp();
    do_reset();
    ss_shift = 4'd3; kp = 16'h0800; ki = 16'h0100; trq_lim = 16'h4000;
    volt_off = 16'h0666; volt_gain = 16'h7800;
    for (int i = 0; i < 12; i++) step(16'h6000, 16'h0400 * 16'(i), "R2 R4 ramp");
    ss_shift = 4'd1;
    for (int i = 0; i < 6; i++) step(16'h1000, 16'h0800, "R2 R4 down");
  endtask

  task automatic t_hold();
    logic [15:0] s0, f0, v0;
    s0 = slip_cmd; f0 = freq_cmd; v0 = volt_cmd;
    @(negedge clk);
    spd_ref = 16'hF000; spd_meas = 16'h0000; kp = 16'hFFFF;
    repeat (5) @(negedge clk);
    chk("R3 slip", longint'(slip_cmd), longint'(s0));
    chk("R3 freq", longint'(freq_cmd), longint'(f0));
    chk("R3 volt", longint'(volt_cmd), longint'(v0));
    kp = 16'h0800;
    step(16'h1000, 16'h0800, "R3 resume");  // state untouched by held cycles
  endtask

  task automatic t_clamp();
    do_reset();
    ss_shift = 4'd0; kp = 16'h2000; ki = 16'h0000; trq_lim = 16'h1800;
    volt_off = 16'h0000; volt_gain = 16'h8000;
    step(16'h1000, 16'h3000, "R5 neg");
    chk("R5 floor zero", longint'(slip_cmd), 0);
    chk("R6 freq=meas", longint'(freq_cmd), 64'h3000);
    step(16'h6000, 16'h1000, "R5 pos");
    chk("R5 ceiling", longint'(slip_cmd), 64'h1800);
  endtask

  task automatic t_sat();
    do_reset();
    ss_shift = 4'd0; kp = 16'h4000; ki = 16'h0000; trq_lim = 16'h2000;
    volt_off = 16'h0CCC; volt_gain = 16'h7333;
    step(16'hFFFF, 16'hF000, "R6 R7 sat");
    chk("R6 freq sat", longint'(freq_cmd), 64'hFFFF);
    chk("R7 volt cap", longint'(volt_cmd), 64'h8000);
    step(16'h1000, 16'h0800, "R7 low");
  endtask

  task automatic t_windup();
    do_reset();
    ss_shift = 4'd0; kp = 16'h0000; ki = 16'h1000; trq_lim = 16'h1000;
    volt_off = 16'h0000; volt_gain = 16'h8000;
    for (int i = 0; i < 20; i++) step(16'h4000, 16'h0000, "R8 pinned");
    step(16'h0800, 16'h0000, "R8 release");
    chk("R8 no windup", longint'(slip_cmd), 64'h0800);
    step(16'h0800, 16'h0000, "R8 accumulate");
    chk("R8 integrates", longint'(slip_cmd), 64'h1000);
  endtask

  initial begin
    fork
      begin
        #(5.0 * 200000);
        if (!done) begin
          errors++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
    t_reset();
    t_passthru();
    t_ramp();
    t_hold();
    t_clamp();
    t_sat();
    t_windup();
    t_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule